// File: doc/BRIEF.md
# I2C Slave Address Match Monitor

This block listens to an I2C bus from the slave side and reports whether the first byte of a transfer is addressed to this device. It brings both bus lines into the clock domain through a synchroniser chain. It recognises start and stop conditions and shifts in the first byte after each start, most significant bit first: seven address bits, then the direction bit on the eighth clock. When that byte completes, it raises an interrupt pulse. It also decides whether to set an address-match status flag and whether to pull SDA low for the acknowledge on the ninth clock.

Two controls change the decision. A format-select input switches to a free-data mode that flags the first word with no address comparison. A no-acknowledge control input turns address matching off. A data-register access strobe, which stands for any read or write of the data buffer, clears the flag. Clocks after the ninth are ignored until the next start condition.

Top module: `i2c_addr_watch`

## Requirements
- R1: While reset is held, and in the first cycle after it, `match_o` and `irq_o` are 0 and `sda_drive_low_o` is 0 (SDA released).
- R2: With `fmt_free_i`=0 and `nack_ctl_i`=0, `match_o` becomes 1 if bits 7..1 of the first byte equal `own_addr_i`, whatever the direction bit. The flag changes on the clock edge that ends the cycle in which the synchronised SCL is first seen high for the eighth bit.
- R3: With `fmt_free_i`=0 and `nack_ctl_i`=0, the general call byte 0x00 (address 0, write direction) sets `match_o`. The byte 0x01 (address 0, read direction) sets nothing unless `own_addr_i` is 0.
- R4: With `nack_ctl_i`=1 and `fmt_free_i`=0, no first byte sets `match_o` or drives an acknowledge, not even the own address or a general call.
- R5: With `fmt_free_i`=1, every completed first byte sets `match_o`, whatever its value and whatever `nack_ctl_i` is.
- R6: A one-cycle `data_acc_i` clears `match_o` on the next edge. If a flag-setting byte completes in that same cycle, the set wins.
- R7: `irq_o` is a single-cycle pulse, issued once for each completed first byte, whether or not it matched.
- R8: `sda_drive_low_o` is 1 from the SCL fall that ends the eighth bit to the SCL fall that ends the ninth bit. This happens only when `nack_ctl_i`=0 and either free-data mode is on or the address matched (own address or general call).
- R9: A start is SDA falling while SCL is high. A repeated start in the middle of a byte restarts the bit count. A stop (SDA rising while SCL is high) in the middle of a byte abandons it, with no interrupt and no flag.
- R10: SCL clocks after the ninth bit cause no interrupt, no flag change and no acknowledge until the next start.
- R11: A non-matching first byte in normal mode gives an interrupt pulse, leaves `match_o` at 0 and leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| own_addr_i | input | 7 | Programmed 7-bit own slave address |
| fmt_free_i | input | 1 | 1 selects free-data format (no address compare) |
| nack_ctl_i | input | 1 | 1 disables address match detection and acknowledge |
| data_acc_i | input | 1 | One-cycle strobe for any data buffer read or write |
| match_o | output | 1 | Address-match status flag |
| irq_o | output | 1 | One-cycle interrupt request when the first byte completes |
| sda_drive_low_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |

## Verification
The assertions assume that `own_addr_i`, `fmt_free_i` and `nack_ctl_i` stay constant from a start condition until the acknowledge clock ends. They also assume each SCL or SDA level is held for more cycles than the synchroniser needs, so that no bus edge is lost. The stimulus changes the configuration only while the bus is idle or before a start. Every bus level is held for six clocks, and SDA changes only while SCL is low, except where a start or stop is intended. The acknowledge-window and bit-count properties assume that SCL toggles only as a bus master would, never with both lines changing in the same cycle.

// File: rtl/i2c_watch_pkg.sv
// Shared types for the I2C address match monitor.
// Assumes a 7-bit addressing scheme is the usual configuration.
package i2c_watch_pkg;

    // Bus events derived from the synchronised lines, one cycle wide each.
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL and SDA into the clock domain and derives bus events.
// Assumes both lines idle high; SYNC_STAGES must be at least 2.
module i2c_line_sync
    import i2c_watch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);

    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_s;
    logic                   sda_s;

    assign scl_s = scl_chain[SYNC_STAGES-1];
    assign sda_s = sda_chain[SYNC_STAGES-1];

    // Synchroniser chains for both lines, reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
        end else begin
            scl_chain[0] <= scl_i;
            sda_chain[0] <= sda_i;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                scl_chain[i] <= scl_chain[i-1];
                sda_chain[i] <= sda_chain[i-1];
            end
        end
    end

    // Previous synchronised levels, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Event decode: edges of SCL, and SDA edges while SCL stays high.
    always_comb begin
        ev_o.scl_rise = scl_s & ~scl_prev;
        ev_o.scl_fall = ~scl_s & scl_prev;
        ev_o.start    = scl_s & scl_prev & sda_prev & ~sda_s;
        ev_o.stop     = scl_s & scl_prev & ~sda_prev & sda_s;
        ev_o.sda      = sda_s;
    end

endmodule

// File: rtl/i2c_first_byte_rx.sv
// Shifts in the first byte after a start and times the acknowledge clock.
// Assumes a bus master that changes SDA only while SCL is low, except to
// signal start or stop. Goes idle after the ninth clock until the next start.
module i2c_first_byte_rx
    import i2c_watch_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_ev_t          ev_i,
    input  logic              ack_hit_i,
    output logic              byte_done_o,
    output logic [BYTE_W-1:0] byte_val_o,
    output logic              ack_o
);

    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] END_BIT  = CNT_W'(BYTE_W + 1);

    logic              active;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              ack_pend;
    logic              ack_q;
    logic              quiet;

    // No start or stop this cycle, so ordinary clocking may proceed.
    assign quiet       = ~ev_i.start & ~ev_i.stop;
    assign byte_done_o = active & quiet & ev_i.scl_rise & (bit_cnt == LAST_BIT);
    assign byte_val_o  = {shreg[BYTE_W-2:0], ev_i.sda};
    assign ack_o       = ack_q;

    // Reception state: active flag, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (ev_i.start) begin
            active  <= 1'b1;
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (ev_i.stop) begin
            active  <= 1'b0;
            bit_cnt <= '0;
        end else if (active) begin
            if (ev_i.scl_rise && bit_cnt < ACK_BIT) begin
                shreg   <= byte_val_o;
                bit_cnt <= bit_cnt + 1'b1;
            end else if (ev_i.scl_rise && bit_cnt == ACK_BIT) begin
                bit_cnt <= END_BIT;
            end else if (ev_i.scl_fall && bit_cnt == END_BIT) begin
                active  <= 1'b0;
                bit_cnt <= '0;
            end
        end
    end

    // Acknowledge decision latch and the SDA pull-down window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_pend <= 1'b0;
            ack_q    <= 1'b0;
        end else if (!quiet) begin
            ack_pend <= 1'b0;
            ack_q    <= 1'b0;
        end else begin
            if (byte_done_o) begin
                ack_pend <= ack_hit_i;
            end
            if (active && ev_i.scl_fall && bit_cnt == ACK_BIT) begin
                ack_q <= ack_pend;
            end else if (active && ev_i.scl_fall && bit_cnt == END_BIT) begin
                ack_q <= 1'b0;
            end
        end
    end

    // R8: the pull-down is only ever active inside the acknowledge clock.
    a_r8_ack_window: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> (bit_cnt >= ACK_BIT));

    // R9: the bit counter never runs past the acknowledge clock.
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= END_BIT);

    // R9: a start always restarts the byte and releases SDA.
    a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i.start |=> (bit_cnt == '0) && !ack_q);

endmodule

// File: rtl/i2c_match_flag.sv
// Compares the completed first byte and keeps the match flag and interrupt.
// Assumes the configuration inputs are stable while a byte is on the bus.
module i2c_match_flag #(
    parameter int ADDR_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_done_i,
    input  logic [ADDR_W:0] byte_val_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic            fmt_free_i,
    input  logic            nack_ctl_i,
    input  logic            data_acc_i,
    output logic            ack_hit_o,
    output logic            match_o,
    output logic            irq_o
);

    logic addr_hit;
    logic gen_call;
    logic flag_set;
    logic match_q;
    logic irq_q;

    // Byte classification: own address (any direction) or general call.
    always_comb begin
        addr_hit  = (byte_val_i[ADDR_W:1] == own_addr_i);
        gen_call  = (byte_val_i == '0);
        flag_set  = fmt_free_i | (~nack_ctl_i & (addr_hit | gen_call));
        ack_hit_o = ~nack_ctl_i & (fmt_free_i | addr_hit | gen_call);
    end

    // Match flag: a completed byte sets it, a data access clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else if (byte_done_i && flag_set) begin
            match_q <= 1'b1;
        end else if (data_acc_i) begin
            match_q <= 1'b0;
        end
    end

    // Interrupt request: one pulse for each completed first byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= byte_done_i;
        end
    end

    assign match_o = match_q;
    assign irq_o   = irq_q;

    // R7: the interrupt request never lasts more than one cycle.
    a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R6: an access with no completing byte leaves the flag clear.
    a_r6_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc_i && !byte_done_i) |=> !match_q);

    // R4: with matching disabled in normal mode, a clear flag stays clear.
    a_r4_nack_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_q && nack_ctl_i && !fmt_free_i) |=> !match_q);

    // R2: the flag only rises together with the interrupt pulse.
    a_r2_rise_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_q) |-> irq_q);

endmodule

// File: rtl/i2c_addr_watch.sv
// Top of the I2C slave address match monitor: synchroniser, first-byte
// receiver and match flag. Assumes slave-only operation on a bus idling high.
module i2c_addr_watch
    import i2c_watch_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              fmt_free_i,
    input  logic              nack_ctl_i,
    input  logic              data_acc_i,
    output logic              match_o,
    output logic              irq_o,
    output logic              sda_drive_low_o
);

    localparam int BYTE_W = ADDR_W + 1;

    line_ev_t          ev;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              ack_hit;

    i2c_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2c_first_byte_rx #(
        .BYTE_W(BYTE_W)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (ev),
        .ack_hit_i   (ack_hit),
        .byte_done_o (byte_done),
        .byte_val_o  (byte_val),
        .ack_o       (sda_drive_low_o)
    );

    i2c_match_flag #(
        .ADDR_W(ADDR_W)
    ) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_done_i (byte_done),
        .byte_val_i  (byte_val),
        .own_addr_i  (own_addr_i),
        .fmt_free_i  (fmt_free_i),
        .nack_ctl_i  (nack_ctl_i),
        .data_acc_i  (data_acc_i),
        .ack_hit_o   (ack_hit),
        .match_o     (match_o),
        .irq_o       (irq_o)
    );

    // R1/R7: the interrupt and the acknowledge never start in the same cycle.
    a_r7_irq_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !$rose(sda_drive_low_o));

endmodule

// File: tb/i2c_addr_watch_tb.sv
module i2c_addr_watch_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic [6:0] own = 7'h5A;
    logic       fmt_free = 1'b0;
    logic       nack_ctl = 1'b0;
    logic       data_acc = 1'b0;
    logic       match_o, irq_o, drv_o;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    int ack_seen = 0;
    localparam int W = 6;

    always #4 clk = ~clk;

    i2c_addr_watch u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .own_addr_i(own), .fmt_free_i(fmt_free), .nack_ctl_i(nack_ctl),
        .data_acc_i(data_acc), .match_o(match_o), .irq_o(irq_o),
        .sda_drive_low_o(drv_o)
    );

    // Behavioural reference: delayed line copies and a transfer tracker.
    int p_scl = 1, p_sda = 1, s_scl = 1, s_sda = 1, q_scl = 1, q_sda = 1;
    int m_act = 0, m_cnt = 0, m_sh = 0, m_pend = 0;
    int m_ack = 0, m_match = 0, m_irq = 0;

    always @(posedge clk) begin
        int st, sp, ri, fa, setf, hit_a, hit_g;
        if (!rst_n) begin
            p_scl = 1; p_sda = 1; s_scl = 1; s_sda = 1; q_scl = 1; q_sda = 1;
            m_act = 0; m_cnt = 0; m_sh = 0; m_pend = 0;
            m_ack = 0; m_match = 0; m_irq = 0;
        end else begin
            st = s_scl && q_scl && q_sda && !s_sda;
            sp = s_scl && q_scl && !q_sda && s_sda;
            ri = s_scl && !q_scl;
            fa = !s_scl && q_scl;
            m_irq = 0;
            setf = 0;
            if (st) begin
                m_act = 1; m_cnt = 0; m_sh = 0; m_ack = 0; m_pend = 0;
            end else if (sp) begin
                m_act = 0; m_cnt = 0; m_ack = 0; m_pend = 0;
            end else if (m_act) begin
                if (ri && m_cnt < 8) begin
                    m_sh = ((m_sh << 1) | s_sda) & 255;
                    m_cnt++;
                    if (m_cnt == 8) begin
                        m_irq = 1;
                        hit_a = ((m_sh >> 1) == int'(own));
                        hit_g = (m_sh == 0);
                        setf = fmt_free || (!nack_ctl && (hit_a || hit_g));
                        m_pend = !nack_ctl && (fmt_free || hit_a || hit_g);
                    end
                end else if (ri && m_cnt == 8) begin
                    m_cnt = 9;
                end else if (fa && m_cnt == 8) begin
                    m_ack = m_pend;
                end else if (fa && m_cnt == 9) begin
                    m_ack = 0; m_act = 0; m_cnt = 0;
                end
            end
            if (setf) m_match = 1;
            else if (data_acc) m_match = 0;
            q_scl = s_scl; q_sda = s_sda;
            s_scl = p_scl; s_sda = p_sda;
            p_scl = int'(scl); p_sda = int'(sda);
        end
    end

    // Cycle-by-cycle comparison against the reference, plus event counters.
    always @(negedge clk) begin
        if (rst_n) begin
            checks += 3;
            if (int'(match_o) != m_match) begin
                errors++;
                $display("FAIL R2 match_o per-cycle: actual %0d expected %0d at %0t", match_o, m_match, $time);
            end
            if (int'(irq_o) != m_irq) begin
                errors++;
                $display("FAIL R7 irq_o per-cycle: actual %0d expected %0d at %0t", irq_o, m_irq, $time);
            end
            if (int'(drv_o) != m_ack) begin
                errors++;
                $display("FAIL R8 sda_drive_low_o per-cycle: actual %0d expected %0d at %0t", drv_o, m_ack, $time);
            end
            if (irq_o) irq_seen++;
            if (drv_o) ack_seen++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic clr_counts();
        irq_seen = 0;
        ack_seen = 0;
    endtask

    task automatic bus_start();
        sda = 1'b1; step(W);
        scl = 1'b1; step(W);
        sda = 1'b0; step(W);
        scl = 1'b0; step(W);
    endtask

    task automatic bus_stop();
        sda = 1'b0; step(W);
        scl = 1'b1; step(W);
        sda = 1'b1; step(W);
    endtask

    task automatic bus_bit(input logic b);
        sda = b;    step(W);
        scl = 1'b1; step(W);
        scl = 1'b0; step(W);
    endtask

    task automatic bus_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    endtask

    task automatic ack_clock();
        bus_bit(1'b1);
    endtask

    task automatic access();
        data_acc = 1'b1; step(1);
        data_acc = 1'b0; step(2);
    endtask

    // Full first-byte transfer followed by stop.
    task automatic xfer(input logic [7:0] b);
        clr_counts();
        bus_start();
        bus_byte(b);
        ack_clock();
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(4);
        // R1: outputs during reset
        chk("R1 match in reset", int'(match_o), 0);
        chk("R1 irq in reset", int'(irq_o), 0);
        chk("R1 sda drive in reset", int'(drv_o), 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 match after reset", int'(match_o), 0);
        chk("R1 drive after reset", int'(drv_o), 0);

        // R2: own address, write direction
        xfer({7'h5A, 1'b0});
        chk("R2 own write match", int'(match_o), 1);
        chk("R7 one irq", irq_seen, 1);
        chk("R8 ack driven", int'(ack_seen > 0), 1);
        // R6: access clears
        access();
        chk("R6 access clears", int'(match_o), 0);

        // R2: own address, read direction
        xfer({7'h5A, 1'b1});
        chk("R2 own read match", int'(match_o), 1);
        access();

        // R3: general call and address 0 read
        xfer(8'h00);
        chk("R3 general call match", int'(match_o), 1);
        chk("R3 general call ack", int'(ack_seen > 0), 1);
        access();
        xfer(8'h01);
        chk("R3 addr0 read no match", int'(match_o), 0);
        chk("R3 addr0 read no ack", ack_seen, 0);

        // R11: non-matching address
        xfer({7'h30, 1'b0});
        chk("R11 no match", int'(match_o), 0);
        chk("R11 irq still", irq_seen, 1);
        chk("R11 no ack", ack_seen, 0);

        // R4: matching disabled
        nack_ctl = 1'b1;
        step(2);
        xfer({7'h5A, 1'b0});
        chk("R4 own blocked", int'(match_o), 0);
        chk("R4 own no ack", ack_seen, 0);
        xfer(8'h00);
        chk("R4 gencall blocked", int'(match_o), 0);
        chk("R4 gencall no ack", ack_seen, 0);

        // R5: free-data mode, with and without nack
        fmt_free = 1'b1;
        step(2);
        xfer(8'h37);
        chk("R5 free nack flag", int'(match_o), 1);
        chk("R8 free nack no ack", ack_seen, 0);
        access();
        nack_ctl = 1'b0;
        step(2);
        xfer(8'hC3);
        chk("R5 free flag", int'(match_o), 1);
        chk("R8 free ack", int'(ack_seen > 0), 1);
        access();
        fmt_free = 1'b0;
        step(2);

        // R9: repeated start mid-byte restarts the count
        clr_counts();
        bus_start();
        bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b0);
        bus_start();
        bus_byte({7'h5A, 1'b0});
        ack_clock();
        bus_stop();
        chk("R9 restart one irq", irq_seen, 1);
        chk("R9 restart match", int'(match_o), 1);
        access();

        // R9: stop mid-byte abandons it
        clr_counts();
        bus_start();
        bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b0);
        bus_stop();
        step(4);
        chk("R9 stop no irq", irq_seen, 0);
        chk("R9 stop no match", int'(match_o), 0);

        // R10: later bytes ignored
        clr_counts();
        bus_start();
        bus_byte({7'h5A, 1'b0});
        ack_clock();
        access();
        ack_seen = 0;
        bus_byte({7'h5A, 1'b0});
        ack_clock();
        bus_stop();
        chk("R10 single irq", irq_seen, 1);
        chk("R10 no second ack", ack_seen, 0);
        chk("R10 no flag", int'(match_o), 0);

        // R6: set wins over a same-cycle access
        clr_counts();
        bus_start();
        for (int i = 7; i >= 1; i--) bus_bit(own[i-1]);
        sda = 1'b0; step(W);
        scl = 1'b1; step(2);
        data_acc = 1'b1; step(1);
        data_acc = 1'b0; step(W - 3);
        scl = 1'b0; step(W);
        ack_clock();
        bus_stop();
        chk("R6 set priority", int'(match_o), 1);
        access();
        chk("R6 cleared after", int'(match_o), 0);

        step(10);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule